// File: doc/BRIEF.md
# DMA Channel Request and Interrupt Control

This block holds the per-channel control and status flags of a 64-channel DMA controller. Four 64-bit flag vectors are kept: request enable, error-interrupt enable, pending interrupt and channel error. Each vector is read and written through a 32-bit register port as an upper word (channels 63..32) and a lower word (channels 31..0). Alongside the word registers, eight byte-wide command ports take a channel number as data. Software uses them to set or clear one channel's flag, or every channel's flag at once, without a read-modify-write of the wide vectors. The same ports also start a channel under software control and clear a descriptor's done bit.

The channel engines report major-loop completions as a 64-bit event vector and report faults one at a time, each with a channel number and a cause code. The block keeps a global error status word that records the first enabled fault. It combines pending work into a single interrupt line. It also gates the sampled peripheral request lines with the request enables before they reach the arbiter, and it emits one-cycle start and done-clear pulses. Register writes take effect at the clock edge that samples them. Reads are combinational from the current address.

Top module: `dma_chan_ctl`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq`, `svc_req`, `start_pulse`, `done_clr_vld`, `done_clr_chan` and `done_clr_all` are zero.
- R2: Word index = `bus_addr[7:2]`, and an access with `bus_addr[1:0]` nonzero does nothing and reads zero. The request-enable vector reads and writes at 0x08 (channels 63..32) and 0x0C (channels 31..0). The error-interrupt-enable vector does the same at 0x10 and 0x14. A write changes only the bytes whose `bus_wbe` bit is set, with byte lane k being `bus_wdata[8k+7:8k]`. Offsets 0x00, 0x18, 0x1C and any unlisted word read zero.
- R3: The command bytes are word 0x18 lanes 0..3, which are set request enable, clear request enable, set error-interrupt enable and clear error-interrupt enable, and word 0x1C lanes 0..3, which are clear interrupt, clear error, start and clear done. A command byte with bit 7 set is ignored. With bit 6 set it addresses all 64 channels, and otherwise bits 5:0 give the channel. When one write both sets and clears the same enable bit, the clear wins.
- R4: `periph_req` is registered once. The registered value reads at 0x30 (63..32) and 0x34 (31..0), and `svc_req` is that registered value ANDed with the request enables.
- R5: A start command raises `start_pulse` for the addressed channel (or all channels) for exactly the one cycle after the write edge.
- R6: A `cpl_evt` bit sets that channel's interrupt flag, which reads at 0x20/0x24. The flag is cleared by the clear-interrupt command or by writing 1s to the word (write-one-to-clear, so all ones clears the word). A completion event in the same cycle as a clear leaves the flag set.
- R7: A fault report (`err_rpt_vld` with `err_rpt_chan`) sets that channel's error flag, which reads at 0x28/0x2C, only if the channel's error-interrupt enable is set. Otherwise it is ignored. Error flags are cleared by the clear-error command or by a write-one-to-clear word write, and a fault wins over a clear in the same cycle.
- R8: The status word at 0x04 is read-only. When an enabled fault sets a flag while bit 31 (valid) is clear, the word captures bit 31 = 1, bits 13:8 = channel, bit 15 = cause[9], bit 14 = cause[8] and bits 7:0 = cause[7:0], with all other bits 0. It then holds that first fault while any error flag is set, and it returns to zero in the cycle the last error flag clears.
- R9: `irq` is high exactly when any interrupt flag is set or any error flag is set on a channel whose error-interrupt enable is set.
- R10: A clear-done command gives, in the cycle after the write edge, a one-cycle `done_clr_vld` with `done_clr_chan` = channel. For an all-channel command it gives `done_clr_all` = 1 with `done_clr_chan` = 0. Outside that pulse both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe |
| bus_wbe | input | 4 | Byte lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| periph_req | input | 64 | Peripheral request lines, one per channel |
| svc_req | output | 64 | Enabled, registered peripheral requests |
| cpl_evt | input | 64 | Per-channel major-loop completion events |
| err_rpt_vld | input | 1 | Fault report strobe |
| err_rpt_chan | input | 6 | Faulting channel |
| err_rpt_cause | input | 10 | Fault cause bits |
| start_pulse | output | 64 | One-cycle software start per channel |
| done_clr_vld | output | 1 | Done-clear request strobe |
| done_clr_chan | output | 6 | Channel whose done bit is cleared |
| done_clr_all | output | 1 | Done-clear applies to all channels |
| irq | output | 1 | Combined interrupt |

## Verification
A behavioural model in the bench is compared with every output and with the read data of the current address on every cycle. Directed sequences come first. They use single-channel and all-channel command bytes, an ignored command byte, and set and clear of the same bit in one write, which tells the two priority orders apart. Partial byte-lane writes separate the word lanes. Completion and fault events that coincide with clears show which side wins. A fault on a channel whose enable is clear, and a second fault while the first is held, show the enable gating and the first-fault capture. A long pseudo-random phase then mixes word writes, command bytes with the ignore and broadcast bits, and sparse events, which exposes interactions between the vectors that the directed cases miss.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int NCH    = 64;
    localparam int CHW    = $clog2(NCH);
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int WIW    = AW - 2;
    localparam int LANES  = DW / 8;
    localparam int NCMD   = 2 * LANES;
    localparam int CAUSEW = 10;

    // command byte order: word A lanes 0..3, then word B lanes 0..3
    typedef enum logic [2:0] {
        CMD_SET_REQ, CMD_CLR_REQ, CMD_SET_EEI, CMD_CLR_EEI,
        CMD_CLR_INT, CMD_CLR_ERR, CMD_START,   CMD_CLR_DONE
    } cmd_e;

    localparam logic [WIW-1:0] W_CTRL   = WIW'(0);
    localparam logic [WIW-1:0] W_STAT   = WIW'(1);
    localparam logic [WIW-1:0] W_REQ_HI = WIW'(2);
    localparam logic [WIW-1:0] W_REQ_LO = WIW'(3);
    localparam logic [WIW-1:0] W_EEI_HI = WIW'(4);
    localparam logic [WIW-1:0] W_EEI_LO = WIW'(5);
    localparam logic [WIW-1:0] W_CMD_A  = WIW'(6);
    localparam logic [WIW-1:0] W_CMD_B  = WIW'(7);
    localparam logic [WIW-1:0] W_INT_HI = WIW'(8);
    localparam logic [WIW-1:0] W_INT_LO = WIW'(9);
    localparam logic [WIW-1:0] W_ERR_HI = WIW'(10);
    localparam logic [WIW-1:0] W_ERR_LO = WIW'(11);
    localparam logic [WIW-1:0] W_HRS_HI = WIW'(12);
    localparam logic [WIW-1:0] W_HRS_LO = WIW'(13);

    typedef struct packed {
        logic           valid;
        logic [14:0]    rsvd;
        logic           grp_prio;
        logic           chn_prio;
        logic [CHW-1:0] chan;
        logic [7:0]     xfer;
    } err_stat_t;

    // channel selection carried by one command byte
    function automatic logic [NCH-1:0] chan_mask(input logic [7:0] b);
        logic [NCH-1:0] m;
        m = '0;
        if (!b[7]) begin
            if (b[6]) m = '1;
            else      m[b[CHW-1:0]] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] lane_bits(input logic [LANES-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction
endpackage

// File: rtl/dcc_cmd_decode.sv
module dcc_cmd_decode
    import dcc_pkg::*;
(
    input  logic                       wr_en,
    input  logic [WIW-1:0]             widx,
    input  logic [LANES-1:0]           wbe,
    input  logic [DW-1:0]              wdata,
    output logic [NCMD-1:0][NCH-1:0]   cmd_mask,
    output logic                       dn_vld,
    output logic [CHW-1:0]             dn_chan,
    output logic                       dn_all
);
    localparam int DL = int'(CMD_CLR_DONE) % LANES;

    for (genvar g = 0; g < NCMD; g++) begin : g_cmd
        localparam int LANE = g % LANES;
        localparam logic [WIW-1:0] WORD = W_CMD_A + WIW'(g / LANES);
        logic hit;
        assign hit         = wr_en && (widx == WORD) && wbe[LANE];
        assign cmd_mask[g] = hit ? chan_mask(wdata[LANE*8 +: 8]) : '0;
    end

    logic [7:0] dbyte;
    assign dbyte   = wdata[DL*8 +: 8];
    assign dn_vld  = wr_en && (widx == W_CMD_B) && wbe[DL] && !dbyte[7];
    assign dn_all  = dbyte[6];
    assign dn_chan = dbyte[6] ? '0 : dbyte[CHW-1:0];
endmodule

// File: rtl/dcc_flag_vec.sv
module dcc_flag_vec
    import dcc_pkg::*;
#(
    parameter bit SET_WINS = 1'b0
)(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set,
    input  logic [NCH-1:0] clr,
    input  logic [NCH-1:0] ld_mask,
    input  logic [NCH-1:0] ld_val,
    output logic [NCH-1:0] q,
    output logic [NCH-1:0] nxt
);
    logic [NCH-1:0] loaded;
    assign loaded = (q & ~ld_mask) | (ld_val & ld_mask);

    if (SET_WINS) begin : g_set_wins
        assign nxt = (loaded & ~clr) | set;
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ((q & $past(set)) == $past(set)));
    end else begin : g_clr_wins
        assign nxt = (loaded | set) & ~clr;
        // R3
        clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ((q & $past(clr)) == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/dcc_err_status.sv
module dcc_err_status
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [CHW-1:0]    chan,
    input  logic [CAUSEW-1:0] cause,
    input  logic              vec_empty,
    output err_stat_t         q
);
    err_stat_t cap;
    always_comb begin
        cap          = '0;
        cap.valid    = 1'b1;
        cap.grp_prio = cause[9];
        cap.chn_prio = cause[8];
        cap.chan     = chan;
        cap.xfer     = cause[7:0];
    end

    always_ff @(posedge clk) begin
        if (rst || vec_empty)     q <= '0;
        else if (hit && !q.valid) q <= cap;
    end

    // R8
    first_fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(q.valid) && q.valid) |-> (q.chan == $past(q.chan)));
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wen,
    input  logic [LANES-1:0]  bus_wbe,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NCH-1:0]    periph_req,
    output logic [NCH-1:0]    svc_req,
    input  logic [NCH-1:0]    cpl_evt,
    input  logic              err_rpt_vld,
    input  logic [CHW-1:0]    err_rpt_chan,
    input  logic [CAUSEW-1:0] err_rpt_cause,
    output logic [NCH-1:0]    start_pulse,
    output logic              done_clr_vld,
    output logic [CHW-1:0]    done_clr_chan,
    output logic              done_clr_all,
    output logic              irq
);
    logic                     aligned, wr_ok;
    logic [WIW-1:0]           widx;
    logic [DW-1:0]            wmask, w1c;
    logic [NCMD-1:0][NCH-1:0] cmd;
    logic                     dn_vld, dn_all;
    logic [CHW-1:0]           dn_chan;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = bus_addr[AW-1:2];
    assign wr_ok   = bus_wen && aligned;
    assign wmask   = lane_bits(bus_wbe);
    assign w1c     = bus_wdata & wmask;

    dcc_cmd_decode u_cmd (
        .wr_en(wr_ok), .widx(widx), .wbe(bus_wbe), .wdata(bus_wdata),
        .cmd_mask(cmd), .dn_vld(dn_vld), .dn_chan(dn_chan), .dn_all(dn_all)
    );

    // word-write load masks and write-one-to-clear masks, upper word first
    function automatic logic [NCH-1:0] pick(input logic [WIW-1:0] hi_w,
                                            input logic [WIW-1:0] lo_w,
                                            input logic [WIW-1:0] idx,
                                            input logic           en,
                                            input logic [DW-1:0]  v);
        return {(en && idx == hi_w) ? v : '0, (en && idx == lo_w) ? v : '0};
    endfunction

    logic [NCH-1:0] req_q, eei_q, int_q, err_q;
    logic [NCH-1:0] req_nxt, eei_nxt, int_nxt, err_nxt;
    logic [NCH-1:0] err_set, one_hot_err;

    dcc_flag_vec #(.SET_WINS(1'b0)) u_req (
        .clk(clk), .rst(rst),
        .set(cmd[CMD_SET_REQ]), .clr(cmd[CMD_CLR_REQ]),
        .ld_mask(pick(W_REQ_HI, W_REQ_LO, widx, wr_ok, wmask)),
        .ld_val({bus_wdata, bus_wdata}),
        .q(req_q), .nxt(req_nxt)
    );

    dcc_flag_vec #(.SET_WINS(1'b0)) u_eei (
        .clk(clk), .rst(rst),
        .set(cmd[CMD_SET_EEI]), .clr(cmd[CMD_CLR_EEI]),
        .ld_mask(pick(W_EEI_HI, W_EEI_LO, widx, wr_ok, wmask)),
        .ld_val({bus_wdata, bus_wdata}),
        .q(eei_q), .nxt(eei_nxt)
    );

    dcc_flag_vec #(.SET_WINS(1'b1)) u_int (
        .clk(clk), .rst(rst),
        .set(cpl_evt),
        .clr(cmd[CMD_CLR_INT] | pick(W_INT_HI, W_INT_LO, widx, wr_ok, w1c)),
        .ld_mask('0), .ld_val('0),
        .q(int_q), .nxt(int_nxt)
    );

    assign one_hot_err = {{(NCH-1){1'b0}}, 1'b1} << err_rpt_chan;
    assign err_set     = (err_rpt_vld && eei_q[err_rpt_chan]) ? one_hot_err : '0;

    dcc_flag_vec #(.SET_WINS(1'b1)) u_err (
        .clk(clk), .rst(rst),
        .set(err_set),
        .clr(cmd[CMD_CLR_ERR] | pick(W_ERR_HI, W_ERR_LO, widx, wr_ok, w1c)),
        .ld_mask('0), .ld_val('0),
        .q(err_q), .nxt(err_nxt)
    );

    logic unused_nxt;
    assign unused_nxt = ^{req_nxt, eei_nxt, int_nxt};

    err_stat_t err_stat;
    dcc_err_status u_stat (
        .clk(clk), .rst(rst),
        .hit(err_set != '0), .chan(err_rpt_chan), .cause(err_rpt_cause),
        .vec_empty(err_nxt == '0),
        .q(err_stat)
    );

    logic [NCH-1:0] hrs_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            hrs_q         <= '0;
            start_pulse   <= '0;
            done_clr_vld  <= 1'b0;
            done_clr_chan <= '0;
            done_clr_all  <= 1'b0;
        end else begin
            hrs_q         <= periph_req;
            start_pulse   <= cmd[CMD_START];
            done_clr_vld  <= dn_vld;
            done_clr_chan <= dn_vld ? dn_chan : '0;
            done_clr_all  <= dn_vld && dn_all;
        end
    end

    assign svc_req = hrs_q & req_q;
    assign irq     = (|int_q) | (|(err_q & eei_q));

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                W_STAT:   bus_rdata = err_stat;
                W_REQ_HI: bus_rdata = req_q[NCH-1:DW];
                W_REQ_LO: bus_rdata = req_q[DW-1:0];
                W_EEI_HI: bus_rdata = eei_q[NCH-1:DW];
                W_EEI_LO: bus_rdata = eei_q[DW-1:0];
                W_INT_HI: bus_rdata = int_q[NCH-1:DW];
                W_INT_LO: bus_rdata = int_q[DW-1:0];
                W_ERR_HI: bus_rdata = err_q[NCH-1:DW];
                W_ERR_LO: bus_rdata = err_q[DW-1:0];
                W_HRS_HI: bus_rdata = hrs_q[NCH-1:DW];
                W_HRS_LO: bus_rdata = hrs_q[DW-1:0];
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8
    stat_valid_tracks_flags_chk: assert property (@(posedge clk) disable iff (rst)
        err_stat.valid == (err_q != '0));

    // R7
    err_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((err_q & ~$past(err_q) & ~$past(eei_q)) == '0));

    // R5
    start_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (start_pulse != '0) |-> $past(bus_wen));

    // R10
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        done_clr_vld |-> $past(bus_wen && widx == W_CMD_B && bus_wbe[LANES-1]));
endmodule

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_wbe = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] periph_req = '0;
    logic [63:0] svc_req;
    logic [63:0] cpl_evt = '0;
    logic        err_rpt_vld = 1'b0;
    logic [5:0]  err_rpt_chan = '0;
    logic [9:0]  err_rpt_cause = '0;
    logic [63:0] start_pulse;
    logic        done_clr_vld;
    logic [5:0]  done_clr_chan;
    logic        done_clr_all;
    logic        irq;

    always #10 clk = ~clk;

    dma_chan_ctl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wbe(bus_wbe), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_req(periph_req), .svc_req(svc_req), .cpl_evt(cpl_evt),
        .err_rpt_vld(err_rpt_vld), .err_rpt_chan(err_rpt_chan),
        .err_rpt_cause(err_rpt_cause), .start_pulse(start_pulse),
        .done_clr_vld(done_clr_vld), .done_clr_chan(done_clr_chan),
        .done_clr_all(done_clr_all), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference state
    logic [63:0] m_req = '0, m_eei = '0, m_int = '0, m_err = '0, m_hrs = '0, m_start = '0;
    logic [31:0] m_stat = '0;
    logic        m_dv = 1'b0, m_da = 1'b0;
    logic [5:0]  m_dc = '0;

    always @(posedge clk) begin : model
        logic [63:0] c [8];
        logic [63:0] nreq, neei, iclr, eclr, eset;
        logic [63:0] nerr;
        logic [7:0]  b;
        int          w, idx;
        logic        dv, da;
        logic [5:0]  dc;
        if (rst) begin
            m_req = '0; m_eei = '0; m_int = '0; m_err = '0; m_hrs = '0;
            m_start = '0; m_stat = '0; m_dv = 0; m_da = 0; m_dc = '0;
        end else begin
            for (int k = 0; k < 8; k++) c[k] = '0;
            nreq = m_req; neei = m_eei; iclr = '0; eclr = '0;
            dv = 0; da = 0; dc = '0;
            w = int'(bus_addr[7:2]);
            if (bus_wen && bus_addr[1:0] == 2'b00) begin
                for (int l = 0; l < 4; l++) begin
                    if (bus_wbe[l]) begin
                        b = bus_wdata[8*l +: 8];
                        case (w)
                            2:  nreq[32 + 8*l +: 8] = b;
                            3:  nreq[8*l +: 8]      = b;
                            4:  neei[32 + 8*l +: 8] = b;
                            5:  neei[8*l +: 8]      = b;
                            6, 7: if (!b[7]) begin
                                idx = (w - 6) * 4 + l;
                                c[idx] = b[6] ? 64'hFFFF_FFFF_FFFF_FFFF : (64'd1 << b[5:0]);
                                if (idx == 7) begin
                                    dv = 1; da = b[6]; dc = b[6] ? 6'd0 : b[5:0];
                                end
                            end
                            8:  iclr[32 + 8*l +: 8] = b;
                            9:  iclr[8*l +: 8]      = b;
                            10: eclr[32 + 8*l +: 8] = b;
                            11: eclr[8*l +: 8]      = b;
                            default: ;
                        endcase
                    end
                end
            end
            eset = (err_rpt_vld && m_eei[err_rpt_chan]) ? (64'd1 << err_rpt_chan) : 64'd0;
            nerr = (m_err & ~(eclr | c[5])) | eset;
            if (nerr == 0)
                m_stat = '0;
            else if (!m_stat[31] && eset != 0)
                m_stat = {1'b1, 15'd0, err_rpt_cause[9], err_rpt_cause[8], err_rpt_chan, err_rpt_cause[7:0]};
            m_req   = (nreq | c[0]) & ~c[1];
            m_eei   = (neei | c[2]) & ~c[3];
            m_int   = (m_int & ~(iclr | c[4])) | cpl_evt;
            m_err   = nerr;
            m_hrs   = periph_req;
            m_start = c[6];
            m_dv = dv; m_da = da; m_dc = dc;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a[7:2])
            6'd1:  return m_stat;
            6'd2:  return m_req[63:32];
            6'd3:  return m_req[31:0];
            6'd4:  return m_eei[63:32];
            6'd5:  return m_eei[31:0];
            6'd8:  return m_int[63:32];
            6'd9:  return m_int[31:0];
            6'd10: return m_err[63:32];
            6'd11: return m_err[31:0];
            6'd12: return m_hrs[63:32];
            6'd13: return m_hrs[31:0];
            default: return '0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a[7:2])
            6'd1:        return "R8";
            6'd8, 6'd9:  return "R6";
            6'd10, 6'd11: return "R7";
            6'd12, 6'd13: return "R4";
            default:     return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare at the falling edge, then return inputs to idle
    task automatic tick();
        @(negedge clk);
        chk("R9", "irq", 64'(irq), 64'((|m_int) | (|(m_err & m_eei))));
        chk("R4", "svc_req", svc_req, m_hrs & m_req);
        chk("R5", "start_pulse", start_pulse, m_start);
        chk("R10", "done_clr", 64'({done_clr_vld, done_clr_all, done_clr_chan}), 64'({m_dv, m_da, m_dc}));
        chk(rd_tag(bus_addr), "bus_rdata", 64'(bus_rdata), 64'(exp_rd(bus_addr)));
        bus_wen = 0; bus_wbe = '0; bus_wdata = '0; cpl_evt = '0;
        err_rpt_vld = 0; err_rpt_chan = '0; err_rpt_cause = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        tick();
        bus_wen = 1; bus_addr = a; bus_wbe = be; bus_wdata = d;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
        tick();
        bus_addr = a;
        tick();
        chk(tag, "readback", 64'(bus_rdata), 64'(e));
    endtask

    task automatic fault(input logic [5:0] ch, input logic [9:0] cause);
        tick();
        err_rpt_vld = 1; err_rpt_chan = ch; err_rpt_cause = cause;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        logic [5:0]  wi;
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        tick();
        chk("R1", "outputs", 64'({irq, done_clr_vld, done_clr_all, done_clr_chan}), 64'd0);
        chk("R1", "start/svc", start_pulse | svc_req, 64'd0);
        for (int i = 0; i < 14; i++) rd_expect(8'(i * 4), 32'd0, "R1");

        // R3 broadcast set, clear-wins collision, ignored byte, single clear
        wr(8'h18, 4'b0001, 32'h0000_0040);
        rd_expect(8'h08, 32'hFFFF_FFFF, "R3");
        wr(8'h18, 4'b0011, 32'h0000_0303);
        rd_expect(8'h0C, 32'hFFFF_FFF7, "R3");
        wr(8'h18, 4'b0010, 32'h0000_8500);
        rd_expect(8'h0C, 32'hFFFF_FFF7, "R3");
        wr(8'h18, 4'b0010, 32'h0000_2A00);
        rd_expect(8'h08, 32'hFFFF_FBFF, "R3");
        // R2 byte-lane write, misaligned access ignored
        wr(8'h0C, 4'b0010, 32'h1234_5678);
        rd_expect(8'h0C, 32'hFFFF_56F7, "R2");
        wr(8'h0D, 4'b1111, 32'h0);
        rd_expect(8'h0C, 32'hFFFF_56F7, "R2");
        rd_expect(8'h0D, 32'h0, "R2");

        // R4 request sampling
        tick();
        periph_req = 64'h0000_0400_0000_0108;
        rd_expect(8'h30, 32'h0000_0400, "R4");
        rd_expect(8'h34, 32'h0000_0108, "R4");
        tick();
        periph_req = 64'h0000_0400_FFFF_0000;
        tick();
        tick();
        chk("R4", "svc_req gated", svc_req, 64'h0000_0000_FFFF_0000 & {32'hFFFF_FBFF, 32'hFFFF_56F7});
        periph_req = '0;

        // R5 start pulses
        wr(8'h1C, 4'b0100, 32'h0009_0000);
        tick();
        chk("R5", "start one", start_pulse, 64'd1 << 9);
        tick();
        chk("R5", "start ends", start_pulse, 64'd0);
        wr(8'h1C, 4'b0100, 32'h0040_0000);
        tick();
        chk("R5", "start all", start_pulse, 64'hFFFF_FFFF_FFFF_FFFF);

        // R6 completion flags
        tick();
        cpl_evt = 64'h8000_0000_0000_0021;
        rd_expect(8'h24, 32'h0000_0021, "R6");
        rd_expect(8'h20, 32'h8000_0000, "R6");
        chk("R9", "irq on completion", 64'(irq), 64'd1);
        wr(8'h1C, 4'b0001, 32'h0000_003F);
        rd_expect(8'h20, 32'h0, "R6");
        tick();
        bus_wen = 1; bus_addr = 8'h24; bus_wbe = 4'hF; bus_wdata = 32'hFFFF_FFFF;
        cpl_evt = 64'h20;
        rd_expect(8'h24, 32'h0000_0020, "R6");
        wr(8'h24, 4'hF, 32'hFFFF_FFFF);
        rd_expect(8'h24, 32'h0, "R6");
        chk("R9", "irq idle", 64'(irq), 64'd0);

        // R10 done clear
        wr(8'h1C, 4'b1000, 32'h0C00_0000);
        tick();
        chk("R10", "done one", 64'({done_clr_vld, done_clr_all, done_clr_chan}), 64'({1'b1, 1'b0, 6'd12}));
        wr(8'h1C, 4'b1000, 32'h4000_0000);
        tick();
        chk("R10", "done all", 64'({done_clr_vld, done_clr_all, done_clr_chan}), 64'({1'b1, 1'b1, 6'd0}));
        wr(8'h1C, 4'b1000, 32'h8C00_0000);
        tick();
        chk("R10", "done ignored", 64'(done_clr_vld), 64'd0);

        // R7 / R8 fault capture
        wr(8'h18, 4'b0100, 32'h0025_0000);
        fault(6'd37, 10'h201);
        rd_expect(8'h04, 32'h8000_A501, "R8");
        rd_expect(8'h28, 32'h0000_0020, "R7");
        fault(6'd40, 10'h002);
        rd_expect(8'h28, 32'h0000_0020, "R7");
        wr(8'h18, 4'b0100, 32'h0028_0000);
        fault(6'd40, 10'h002);
        rd_expect(8'h28, 32'h0000_0120, "R7");
        rd_expect(8'h04, 32'h8000_A501, "R8");
        wr(8'h04, 4'hF, 32'hFFFF_FFFF);
        rd_expect(8'h04, 32'h8000_A501, "R8");
        wr(8'h1C, 4'b0010, 32'h0000_2500);
        rd_expect(8'h28, 32'h0000_0100, "R7");
        rd_expect(8'h04, 32'h8000_A501, "R8");
        chk("R9", "irq on error", 64'(irq), 64'd1);
        wr(8'h18, 4'b1000, 32'h2800_0000);
        tick();
        chk("R9", "irq masked error", 64'(irq), 64'd0);
        wr(8'h28, 4'hF, 32'hFFFF_FFFF);
        rd_expect(8'h28, 32'h0, "R7");
        rd_expect(8'h04, 32'h0, "R8");

        // mixed pseudo-random traffic, every output compared each cycle
        for (int n = 0; n < 3000; n++) begin
            tick();
            periph_req = {$urandom, $urandom};
            if ($urandom % 4 == 0) cpl_evt = 64'd1 << ($urandom % 64);
            if ($urandom % 5 == 0) begin
                err_rpt_vld = 1; err_rpt_chan = 6'($urandom); err_rpt_cause = 10'($urandom);
            end
            wi = 6'($urandom % 14);
            if ($urandom % 3 == 0) begin
                d = $urandom;
                if (wi == 6 || wi == 7) begin
                    for (int l = 0; l < 4; l++) begin
                        d[8*l + 7] = ($urandom % 8 == 0);
                        d[8*l + 6] = ($urandom % 10 == 0);
                    end
                end else if (wi >= 8) begin
                    d = d & $urandom & $urandom;
                end
                bus_wen = 1; bus_wbe = 4'($urandom); bus_wdata = d;
            end
            bus_addr = {wi, 2'b00};
        end
        tick();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule